// File: doc/BRIEF.md
# Hall Commutation Decoder with Brake

This block turns the three digital Hall sensor lines of a brushless motor, together with a rotation-direction bit, into six gate commands for a three-phase half-bridge set. Each phase has one high-side and one low-side command. For each valid rotor position, exactly one phase is sourced from the supply and one phase is sunk to ground. The third phase floats. The commands feed a downstream dead-time and PWM stage, and are not meant to drive transistors directly.

Around the six-step table, the block applies several overrides. Sleep and the supervisor's global disable switch every gate off. A brake input, active low and failing safe, shorts the motor through all three low-side switches. Hall codes that cannot occur on a healthy sensor set blank the whole bridge for as long as they last, and nothing is latched. The PWM-on input removes the high-side command during off-time, while the low side keeps carrying recirculating current. A per-phase bootstrap-ready flag keeps a high-side switch off while its floating supply is low, and turns on that phase's low side instead so the supply can recharge.

Top module: `hall_commutator`

## Requirements
- R1: The Hall lines pass through two flip-flops. A change of Hall code applied before clock edge k first appears on the gate outputs after edge k+1, and the outputs still show the old code after edge k.
- R2: With `dir`=1 and the code written as {hall_a,hall_b,hall_c}, the source and sink phases are: 101→A and C; 100→B and C; 110→B and A; 010→C and A; 011→C and B; 001→A and B. In every vector, bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: With `dir`=0, the source and sink phases are: 101→C and B; 100→A and B; 110→A and C; 010→B and C; 011→B and A; 001→C and A.
- R4: Codes 000 and 111 switch all six gates off. A following valid code drives the bridge again with no other action, so the condition is not held.
- R5: While brake is asserted, and neither sleep nor disable is active, `gate_lo`=111 and `gate_hi`=000. This holds whatever the values of `pwm_on`, the Hall code and `boot_ok`.
- R6: Only a logic-high `brake_n` releases the brake. A low or undriven (high-impedance) `brake_n` brakes.
- R7: `sleep` or `drv_off` high forces all six gates to 0, and this takes priority over the brake.
- R8: With `pwm_on`=0, no high-side gate is on and the sink phase's low-side gate stays on.
- R9: A source phase whose `boot_ok` bit is 0 gets its high-side gate off and its own low-side gate on. The sink phase's low side is unaffected.
- R10: While `rst_n` is low, all six gates are 0. After reset, the synchronized code starts at 000.
- R11: No phase ever has its high and low gate on together, and at most one high-side gate is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_a | input | 1 | Hall sensor, phase A (asynchronous) |
| hall_b | input | 1 | Hall sensor, phase B (asynchronous) |
| hall_c | input | 1 | Hall sensor, phase C (asynchronous) |
| dir | input | 1 | Rotation direction select |
| brake_n | input | 1 | Brake, active low; only logic 1 releases |
| pwm_on | input | 1 | PWM on-time indicator |
| sleep | input | 1 | Sleep, all gates off |
| drv_off | input | 1 | Supervisor global disable |
| boot_ok | input | 3 | Bootstrap supply above threshold, per phase (bit0=A) |
| gate_hi | output | 3 | High-side gate commands (bit0=A) |
| gate_lo | output | 3 | Low-side gate commands (bit0=A) |

## Verification
The hardest case to reach from the ports is the bootstrap recharge during a commutation step. There, the source phase must swap its high-side command for its own low-side command, while the sink phase keeps its low side and the floating phase stays quiet. Only one `boot_ok` bit out of eight patterns matters for any given Hall code. The bench therefore holds each synchronized code and sweeps every `boot_ok` pattern against both directions, both PWM states and all brake and disable levels, including an undriven brake line. It compares each result with a table rebuilt arithmetically from the step index of the code.

// File: rtl/hall_commutator.sv
module hall_commutator (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hall_a,
  input  logic       hall_b,
  input  logic       hall_c,
  input  logic       dir,
  input  logic       brake_n,
  input  logic       pwm_on,
  input  logic       sleep,
  input  logic       drv_off,
  input  logic [2:0] boot_ok,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);

  logic [2:0] hall_m, hall_q;
  logic [2:0] src, snk;
  logic [2:0] recharge;
  logic       kill, braking;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_m <= 3'b000;
      hall_q <= 3'b000;
    end else begin
      hall_m <= {hall_a, hall_b, hall_c};
      hall_q <= hall_m;
    end
  end

  // one-hot source/sink phase, bit0 = A
  always_comb begin
    src = 3'b000;
    snk = 3'b000;
    unique case ({dir, hall_q})
      4'b1101: begin src = 3'b001; snk = 3'b100; end
      4'b1100: begin src = 3'b010; snk = 3'b100; end
      4'b1110: begin src = 3'b010; snk = 3'b001; end
      4'b1010: begin src = 3'b100; snk = 3'b001; end
      4'b1011: begin src = 3'b100; snk = 3'b010; end
      4'b1001: begin src = 3'b001; snk = 3'b010; end
      4'b0101: begin src = 3'b100; snk = 3'b010; end
      4'b0100: begin src = 3'b001; snk = 3'b010; end
      4'b0110: begin src = 3'b001; snk = 3'b100; end
      4'b0010: begin src = 3'b010; snk = 3'b100; end
      4'b0011: begin src = 3'b010; snk = 3'b001; end
      4'b0001: begin src = 3'b100; snk = 3'b001; end
      default: begin src = 3'b000; snk = 3'b000; end
    endcase
  end

  // a floating or low brake line brakes
  assign braking  = (brake_n !== 1'b1);
  assign kill     = sleep | drv_off | ~rst_n;
  assign recharge = src & ~boot_ok;

  always_comb begin
    if (kill) begin
      gate_hi = 3'b000;
      gate_lo = 3'b000;
    end else if (braking) begin
      gate_hi = 3'b000;
      gate_lo = 3'b111;
    end else begin
      gate_hi = pwm_on ? (src & boot_ok) : 3'b000;
      gate_lo = snk | recharge;
    end
  end

endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall_q,
  input logic       brake_n,
  input logic       pwm_on,
  input logic       sleep,
  input logic       drv_off,
  input logic [2:0] boot_ok,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo
);

  assert_no_shoot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi & gate_lo) == 3'b000) && $onehot0(gate_hi));

  assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || drv_off) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_brake_lows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_n == 1'b0 && !sleep && !drv_off) |-> (gate_hi == 3'b000 && gate_lo == 3'b111));

  assert_bad_code_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hall_q == 3'b000 || hall_q == 3'b111) && brake_n == 1'b1)
      |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_boot_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & ~boot_ok) == 3'b000);

  assert_offtime_no_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |-> (gate_hi == 3'b000));

endmodule

bind hall_commutator hall_commutator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hall_q(hall_q), .brake_n(brake_n),
  .pwm_on(pwm_on), .sleep(sleep), .drv_off(drv_off), .boot_ok(boot_ok),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic dir = 1'b1, brk_drv = 1'b1, brk_z = 1'b0, pwm_on = 1'b1;
  logic sleep = 1'b0, drv_off = 1'b0;
  logic [2:0] boot_ok = 3'b111;
  logic [2:0] gate_hi, gate_lo;
  logic brake_line;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign brake_line = brk_z ? 1'bz : brk_drv;

  hall_commutator dut (
    .clk(clk), .rst_n(rst_n), .hall_a(hall[2]), .hall_b(hall[1]), .hall_c(hall[0]),
    .dir(dir), .brake_n(brake_line), .pwm_on(pwm_on), .sleep(sleep),
    .drv_off(drv_off), .boot_ok(boot_ok), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic int step_of(input logic [2:0] c);
    case (c)
      3'b101: return 0; 3'b100: return 1; 3'b110: return 2;
      3'b010: return 3; 3'b011: return 4; 3'b001: return 5;
      default: return -1;
    endcase
  endfunction

  // expected {hi,lo} built from the step index
  function automatic logic [5:0] expect_gates(input logic [2:0] c, input logic d,
      input logic brk, input logic pw, input logic [2:0] bo, input logic off);
    int s, hp, lp;
    logic [2:0] hi, lo;
    if (off) return 6'b000_000;
    if (brk) return 6'b000_111;
    s = step_of(c);
    if (s < 0) return 6'b000_000;
    hp = d ? ((s + 1) / 2) % 3 : ((s + 1) / 2 + 2) % 3;
    lp = d ? (s / 2 + 2) % 3 : (s / 2 + 1) % 3;
    hi = 3'b000; lo = 3'b000;
    lo[lp] = 1'b1;
    if (bo[hp]) hi[hp] = pw; else lo[hp] = 1'b1;
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if ({gate_hi, gate_lo} !== exp) begin
      errors++;
      $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b", req,
               gate_hi, gate_lo, exp[5:3], exp[2:0]);
    end
  endtask

  task automatic settle_code(input logic [2:0] c);
    @(negedge clk); hall = c;
    @(negedge clk); @(negedge clk); #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hall = 3'b101; brk_drv = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R10 reset", 6'b000_000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 sync starts 000", 6'b000_000);

    // R1 latency: first edge no change, second edge change
    settle_code(3'b100);
    @(negedge clk); hall = 3'b110;
    @(negedge clk); #1;
    check("R1 one edge keeps old", expect_gates(3'b100, 1, 0, 1, 3'b111, 0));
    @(negedge clk); #1;
    check("R1 two edges new code", expect_gates(3'b110, 1, 0, 1, 3'b111, 0));

    // R2/R3/R4/R5/R7/R8/R9 sweep
    for (int c = 0; c < 8; c++) begin
      settle_code(3'(c));
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 2; p++)
          for (int b = 0; b < 8; b++)
            for (int m = 0; m < 4; m++) begin
              dir = d[0]; pwm_on = p[0]; boot_ok = 3'(b);
              brk_drv = ~m[0]; drv_off = m[1]; sleep = 1'b0; #1;
              if (m[1]) check("R7 disable", expect_gates(3'(c), d[0], m[0], p[0], 3'(b), 1));
              else if (m[0]) check("R5 brake", expect_gates(3'(c), d[0], 1, p[0], 3'(b), 0));
              else if (step_of(3'(c)) < 0) check("R4 bad code", 6'b000_000);
              else if (b != 7) check("R9 boot recharge", expect_gates(3'(c), d[0], 0, p[0], 3'(b), 0));
              else if (!p[0]) check("R8 offtime", expect_gates(3'(c), d[0], 0, 0, 3'(b), 0));
              else if (d[0]) check("R2 dir1 table", expect_gates(3'(c), 1, 0, 1, 3'b111, 0));
              else check("R3 dir0 table", expect_gates(3'(c), 0, 0, 1, 3'b111, 0));
            end
    end
    dir = 1'b1; pwm_on = 1'b1; boot_ok = 3'b111; brk_drv = 1'b1; drv_off = 1'b0;

    // R4 not held: invalid then valid
    settle_code(3'b111);
    check("R4 111 off", 6'b000_000);
    settle_code(3'b011);
    check("R4 recovers", expect_gates(3'b011, 1, 0, 1, 3'b111, 0));

    // R7 sleep beats brake
    sleep = 1'b1; brk_drv = 1'b0; #1;
    check("R7 sleep over brake", 6'b000_000);
    sleep = 1'b0; #1;
    check("R5 brake after sleep", 6'b000_111);
    brk_drv = 1'b1;

    // R6 floating brake line brakes
    brk_z = 1'b1; #1;
    check("R6 open brake", 6'b000_111);
    brk_z = 1'b0; #1;
    check("R6 high releases", expect_gates(3'b011, 1, 0, 1, 3'b111, 0));

    // R11 spot check on every valid code
    for (int c = 1; c < 7; c++) begin
      settle_code(3'(c));
      checks++;
      if ((gate_hi & gate_lo) != 0 || $countones(gate_hi) > 1) begin
        errors++;
        $display("FAIL R11: got hi=%b lo=%b expected disjoint", gate_hi, gate_lo);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule